// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is the host-facing half of an I2C master. A byte-wide register file holds the bit-rate prescaler, a control byte, the transmit and receive data, and a command/status location. Software writes one command byte. The block then sequences an external bit-level engine through a start condition, eight data bits, the acknowledge bit and an optional stop condition. It reports progress through a status byte and a level interrupt.

The bit engine owns the SCL/SDA timing, and the prescaler value is passed to it unchanged. This block presents one bit operation at a time on `bit_cmd_o` and `bit_din_o`. It holds that operation until the engine returns a single-cycle `bit_done_i`, which comes with the sampled bus level on `bit_dout_i`. A command byte written while a transfer is in progress has its start/stop/read/write bits dropped. Its interrupt-clear bit still acts.

Top module: `i2cm_ctrl`

## Requirements
- R1: Register offsets are shifted left by `STRIDE_LOG2` to form the bus address. The offsets are:
  - 0: prescale low byte.
  - 1: prescale high byte.
  - 2: control.
  - 3: data (transmit on write, received byte on read).
  - 4: command on write and status on read.
  
  Prescale, control and the received byte read back at their offsets, and `prescale_o` presents {high, low}.
- R2: Only bits 7:0 of a bus write are stored. Bits above 7 of every read are zero.
- R3: Control bit 7 enables the core and is driven on `core_en_o`. Control bit 6 enables the interrupt. The control byte reads back with those two bits and zeros elsewhere.
- R4: A command with bit 4 (write) set emits the following bit operations, then finishes:
  - START (code 1), only if bit 7 is set.
  - Eight WRITE operations (code 3) carrying the data register MSB first on `bit_din_o`.
  - One READ (code 4) for the slave acknowledge.
  - STOP (code 2), only if bit 6 is set.
  
  Status bit 1 (transfer in progress) reads 1 from the clock edge that stores the command until the last bit operation completes.
- R5: A command with bit 5 (read) set emits the following bit operations:
  - Eight READ operations that assemble the received byte MSB first. That byte is readable at offset 3.
  - One WRITE whose `bit_din_o` equals command bit 3 (1 = NACK).
  - STOP, only if command bit 6 is set.
- R6: Status bit 7 holds the acknowledge level sampled after the last written byte (1 = NACK). A read transfer leaves it unchanged.
- R7: Status bit 0 (interrupt flag) sets when a command finishes or arbitration is lost. It stays set until a command byte with bit 0 set is written. A command byte of 0x01 only clears the flag.
- R8: `irq_o` is the level of interrupt flag AND control bit 6 AND control bit 7. The flag and the other status bits behave the same with the interrupt disabled.
- R9: A one-cycle `arb_lost_i` during a transfer has these effects:
  - The command is aborted, and `bit_cmd_o` returns to idle (code 0) by the next cycle.
  - Transfer in progress clears.
  - The interrupt flag sets.
  - Status bit 5 sets and stays set until a command with bit 7 set is written.
- R10: Status bit 6 reports `bus_busy_i`.
- R11: While control bit 7 is 0, the following hold:
  - Command writes, including the interrupt clear, have no effect.
  - `bit_cmd_o` stays idle.
  - The interrupt flag is kept.
  - The prescale registers still accept writes.
- R12: After reset the following values hold:
  - `prescale_o` is 0xFFFF.
  - Control, data and status read 0.
  - `irq_o` is 0 and `bit_cmd_o` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | AW | Register byte address |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | BUS_W | Write data, low byte significant |
| reg_rdata_o | output | BUS_W | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |
| prescale_o | output | 16 | Prescaler value for the bit engine |
| core_en_o | output | 1 | Core enable for the bit engine |
| bit_cmd_o | output | 3 | Bit operation: 0 idle, 1 start, 2 stop, 3 write, 4 read |
| bit_din_o | output | 1 | Level to drive for a write bit |
| bit_done_i | input | 1 | Bit operation finished, one cycle |
| bit_dout_i | input | 1 | Sampled SDA, valid with `bit_done_i` |
| arb_lost_i | input | 1 | Arbitration lost, one cycle |
| bus_busy_i | input | 1 | Bus between start and stop |

## Verification
The assertions assume the following about the bit engine:
- It pulses `bit_done_i` only while a bit operation is presented.
- It raises `arb_lost_i` for a single cycle, and never in the same cycle as `bit_done_i`.

The bench's engine model meets these assumptions. It answers each presented operation two cycles later with a one-cycle done or arbitration-lost pulse, and it never does both. Register writes are one-cycle strobes issued between clock edges. The bench leaves at least one idle cycle between writes, so a command is never written twice before the sequencer has accepted it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam int OFF_PRE_LO = 0;
  localparam int OFF_PRE_HI = 1;
  localparam int OFF_CTRL   = 2;
  localparam int OFF_DATA   = 3;
  localparam int OFF_CMD    = 4;

  // command byte bit positions
  localparam int CB_STA  = 7;
  localparam int CB_STO  = 6;
  localparam int CB_RD   = 5;
  localparam int CB_WR   = 4;
  localparam int CB_ACK  = 3;
  localparam int CB_IACK = 0;

  typedef enum logic [2:0] {
    BC_IDLE  = 3'd0,
    BC_START = 3'd1,
    BC_STOP  = 3'd2,
    BC_WRITE = 3'd3,
    BC_READ  = 3'd4
  } bit_cmd_e;

  typedef struct packed {
    logic sta;
    logic sto;
    logic rd;
    logic wr;
    logic ack;
  } byte_cmd_t;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          BUS_W       = 32,
  parameter int          STRIDE_LOG2 = 2,
  parameter logic [15:0] PRE_RST     = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [BYTE_W-1:0] rx_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic              tip_i,
  input  logic              accept_i,
  output logic [15:0]       prescale_o,
  output logic              en_o,
  output logic              ien_o,
  output logic [BYTE_W-1:0] tx_o,
  output byte_cmd_t         cmd_o,
  output logic              iack_o,
  output logic              sta_wr_o
);
  logic [AW-1:0]     off;
  logic [BYTE_W-1:0] wb;
  logic              hit_lo, hit_hi, hit_ctrl, hit_data, hit_cmd;
  logic              cmd_wr, cmd_new;
  logic [BYTE_W-1:0] rd_byte;

  assign off = addr_i >> STRIDE_LOG2;
  assign wb  = wdata_i[BYTE_W-1:0];

  if (BUS_W > BYTE_W) begin : g_wide
    logic unused_hi;
    assign unused_hi = ^wdata_i[BUS_W-1:BYTE_W];
  end

  assign hit_lo   = (off == AW'(OFF_PRE_LO));
  assign hit_hi   = (off == AW'(OFF_PRE_HI));
  assign hit_ctrl = (off == AW'(OFF_CTRL));
  assign hit_data = (off == AW'(OFF_DATA));
  assign hit_cmd  = (off == AW'(OFF_CMD));

  // commands only count while the core is enabled
  assign cmd_wr   = wr_i & hit_cmd & en_o;
  assign cmd_new  = cmd_wr & ~tip_i;
  assign iack_o   = cmd_wr & wb[CB_IACK];
  assign sta_wr_o = cmd_new & wb[CB_STA];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prescale_o <= PRE_RST;
      en_o       <= 1'b0;
      ien_o      <= 1'b0;
      tx_o       <= '0;
    end else if (wr_i) begin
      if (hit_lo)   prescale_o[7:0]  <= wb;
      if (hit_hi)   prescale_o[15:8] <= wb;
      if (hit_ctrl) begin
        en_o  <= wb[7];
        ien_o <= wb[6];
      end
      if (hit_data) tx_o <= wb;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o <= '0;
    end else if (!en_o) begin
      cmd_o <= '0;
    end else if (cmd_new) begin
      cmd_o <= '{sta: wb[CB_STA], sto: wb[CB_STO], rd: wb[CB_RD],
                 wr: wb[CB_WR], ack: wb[CB_ACK]};
    end else if (accept_i) begin
      cmd_o <= '0;
    end
  end

  always_comb begin
    rd_byte = '0;
    if (hit_lo)   rd_byte = prescale_o[7:0];
    if (hit_hi)   rd_byte = prescale_o[15:8];
    if (hit_ctrl) rd_byte = {en_o, ien_o, 6'b0};
    if (hit_data) rd_byte = rx_i;
    if (hit_cmd)  rd_byte = status_i;
    rdata_o = BUS_W'(rd_byte);
  end
endmodule

// File: rtl/i2cm_byte_seq.sv
module i2cm_byte_seq
  import i2cm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  byte_cmd_t         cmd_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              bit_done_i,
  input  logic              bit_dout_i,
  input  logic              arb_lost_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              nack_o,
  output bit_cmd_e          bit_cmd_o,
  output logic              bit_din_o
);
  typedef enum logic [2:0] {SQ_IDLE, SQ_START, SQ_DATA, SQ_ACK, SQ_STOP} seq_e;

  seq_e              state_q;
  byte_cmd_t         op_q;
  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              go, step;
  logic [BYTE_W-1:0] sr_in;

  assign go       = cmd_i.sta | cmd_i.sto | cmd_i.rd | cmd_i.wr;
  assign accept_o = en_i & (state_q == SQ_IDLE) & go;
  assign busy_o   = (state_q != SQ_IDLE);
  assign step     = en_i & bit_done_i & ~arb_lost_i;
  assign sr_in    = {sr_q[BYTE_W-2:0], op_q.rd ? bit_dout_i : 1'b0};

  // finishing edge of a command
  always_comb begin
    done_o = 1'b0;
    if (step) begin
      case (state_q)
        SQ_START: done_o = ~(op_q.rd | op_q.wr | op_q.sto);
        SQ_ACK:   done_o = ~op_q.sto;
        SQ_STOP:  done_o = 1'b1;
        default:  done_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      op_q    <= '0;
      sr_q    <= '0;
      cnt_q   <= '0;
      rx_o    <= '0;
      nack_o  <= 1'b0;
    end else if (!en_i) begin
      state_q <= SQ_IDLE;
    end else if (arb_lost_i && busy_o) begin
      state_q <= SQ_IDLE;
    end else begin
      case (state_q)
        SQ_IDLE: if (go) begin
          op_q    <= cmd_i;
          sr_q    <= tx_i;
          cnt_q   <= CNT_W'(BYTE_W - 1);
          state_q <= cmd_i.sta ? SQ_START :
                     (cmd_i.rd | cmd_i.wr) ? SQ_DATA : SQ_STOP;
        end
        SQ_START: if (step) begin
          state_q <= (op_q.rd | op_q.wr) ? SQ_DATA :
                     op_q.sto ? SQ_STOP : SQ_IDLE;
        end
        SQ_DATA: if (step) begin
          sr_q <= sr_in;
          if (cnt_q == '0) begin
            state_q <= SQ_ACK;
            if (op_q.rd) rx_o <= sr_in;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_ACK: if (step) begin
          if (!op_q.rd) nack_o <= bit_dout_i;
          state_q <= op_q.sto ? SQ_STOP : SQ_IDLE;
        end
        SQ_STOP: if (step) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    bit_cmd_o = BC_IDLE;
    bit_din_o = 1'b1;
    case (state_q)
      SQ_START: bit_cmd_o = BC_START;
      SQ_DATA: begin
        bit_cmd_o = op_q.rd ? BC_READ : BC_WRITE;
        bit_din_o = op_q.rd ? 1'b1 : sr_q[BYTE_W-1];
      end
      SQ_ACK: begin
        bit_cmd_o = op_q.rd ? BC_WRITE : BC_READ;
        bit_din_o = op_q.rd ? op_q.ack : 1'b1;
      end
      SQ_STOP: bit_cmd_o = BC_STOP;
      default: bit_cmd_o = BC_IDLE;
    endcase
  end
endmodule

// File: rtl/i2cm_status.sv
module i2cm_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ien_i,
  input  logic done_i,
  input  logic arb_lost_i,
  input  logic iack_i,
  input  logic sta_wr_i,
  output logic flag_o,
  output logic al_o,
  output logic irq_o
);
  logic arb_ev;
  assign arb_ev = arb_lost_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      al_o   <= 1'b0;
    end else begin
      if (done_i | arb_ev) flag_o <= 1'b1;
      else if (iack_i)     flag_o <= 1'b0;
      if (arb_ev)          al_o <= 1'b1;
      else if (sta_wr_i)   al_o <= 1'b0;
    end
  end

  assign irq_o = flag_o & ien_i & en_i;
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          BUS_W       = 32,
  parameter int          STRIDE_LOG2 = 2,
  parameter logic [15:0] PRE_RST     = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [BUS_W-1:0] reg_wdata_i,
  output logic [BUS_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic [15:0]      prescale_o,
  output logic             core_en_o,
  output logic [2:0]       bit_cmd_o,
  output logic             bit_din_o,
  input  logic             bit_done_i,
  input  logic             bit_dout_i,
  input  logic             arb_lost_i,
  input  logic             bus_busy_i
);
  logic              ien, iack, sta_wr, accept, seq_busy, seq_done, nack, tip;
  logic              st_flag, st_al;
  logic [BYTE_W-1:0] tx_byte, rx_byte, status;
  byte_cmd_t         pend;
  bit_cmd_e          bc;

  assign tip       = pend.sta | pend.sto | pend.rd | pend.wr | seq_busy;
  assign status    = {nack, bus_busy_i, st_al, 3'b000, tip, st_flag};
  assign bit_cmd_o = bc;

  i2cm_regs #(
    .AW(AW), .BUS_W(BUS_W), .STRIDE_LOG2(STRIDE_LOG2), .PRE_RST(PRE_RST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .rx_i       (rx_byte),
    .status_i   (status),
    .tip_i      (tip),
    .accept_i   (accept),
    .prescale_o (prescale_o),
    .en_o       (core_en_o),
    .ien_o      (ien),
    .tx_o       (tx_byte),
    .cmd_o      (pend),
    .iack_o     (iack),
    .sta_wr_o   (sta_wr)
  );

  i2cm_byte_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (core_en_o),
    .cmd_i      (pend),
    .tx_i       (tx_byte),
    .bit_done_i (bit_done_i),
    .bit_dout_i (bit_dout_i),
    .arb_lost_i (arb_lost_i),
    .accept_o   (accept),
    .busy_o     (seq_busy),
    .done_o     (seq_done),
    .rx_o       (rx_byte),
    .nack_o     (nack),
    .bit_cmd_o  (bc),
    .bit_din_o  (bit_din_o)
  );

  i2cm_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (core_en_o),
    .ien_i      (ien),
    .done_i     (seq_done),
    .arb_lost_i (arb_lost_i),
    .iack_i     (iack),
    .sta_wr_i   (sta_wr),
    .flag_o     (st_flag),
    .al_o       (st_al),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_en,
  input logic [2:0] bit_cmd,
  input logic       flag,
  input logic       al,
  input logic       iack,
  input logic       sta_wr,
  input logic       tip,
  input logic       seq_done,
  input logic       seq_busy,
  input logic       arb_lost
);
  // R11
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_en |=> bit_cmd == 3'd0);

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag) |-> $past(iack));

  // R7
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(seq_done || arb_lost));

  // R9
  al_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(al) |-> $past(sta_wr));

  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost && seq_busy && core_en) |=> !seq_busy);

  // R4
  tip_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tip) |-> $past(seq_done || arb_lost || !core_en));
endmodule

bind i2cm_ctrl i2cm_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .core_en  (core_en_o),
  .bit_cmd  (bit_cmd_o),
  .flag     (st_flag),
  .al       (st_al),
  .iack     (iack),
  .sta_wr   (sta_wr),
  .tip      (tip),
  .seq_done (seq_done),
  .seq_busy (seq_busy),
  .arb_lost (arb_lost_i)
);

// File: tb/sim_i2cm_ctrl.sv
module sim_i2cm_ctrl;
  localparam int AW     = 8;
  localparam int BUS_W  = 32;
  localparam int STRIDE = 2;

  localparam logic [2:0] C_START = 3'd1, C_STOP = 3'd2, C_WRITE = 3'd3, C_READ = 3'd4;

  typedef struct packed {
    logic [2:0] cmd;
    logic       din;
    logic       dout;
    logic       arb;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic             wr = 1'b0;
  logic [BUS_W-1:0] wdata = '0;
  logic [BUS_W-1:0] rdata;
  logic             irq, core_en, bit_din;
  logic [15:0]      prescale;
  logic [2:0]       bit_cmd;
  logic             bit_done = 1'b0, bit_dout = 1'b0, arb = 1'b0, busy = 1'b0;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  i2cm_ctrl #(.AW(AW), .BUS_W(BUS_W), .STRIDE_LOG2(STRIDE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .prescale_o(prescale), .core_en_o(core_en), .bit_cmd_o(bit_cmd),
    .bit_din_o(bit_din), .bit_done_i(bit_done), .bit_dout_i(bit_dout),
    .arb_lost_i(arb), .bus_busy_i(busy)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic d, input logic o, input logic a);
    exp_q.push_back('{cmd: c, din: d, dout: o, arb: a});
  endtask

  task automatic push_wbyte(input logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) push(C_WRITE, b[i], 1'b0, 1'b0);
    push(C_READ, 1'b1, nack, 1'b0);
  endtask

  task automatic push_rbyte(input logic [7:0] b, input logic ackbit);
    for (int i = 7; i >= 0; i--) push(C_READ, 1'b1, b[i], 1'b0);
    push(C_WRITE, ackbit, 1'b0, 1'b0);
  endtask

  task automatic wr_reg(input int off, input logic [31:0] d);
    @(negedge clk);
    addr  = AW'(off << STRIDE);
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic rd_reg(input int off, output logic [31:0] v);
    @(negedge clk);
    addr = AW'(off << STRIDE);
    #1 v = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd_reg(4, s);
      if (s[1] == 1'b0) break;
    end
  endtask

  // monitor: bit engine model and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bit_cmd !== 3'd0) begin
        if (exp_q.size() == 0) begin
          chk("R11", "unexpected bit command", 32'(bit_cmd), 32'd0);
          repeat (2) @(negedge clk);
          bit_done = 1'b1;
          @(negedge clk);
          bit_done = 1'b0;
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          chk("R4 R5", "bit command", 32'(bit_cmd), 32'(it.cmd));
          if (it.cmd == C_WRITE) chk("R4 R5", "bit data", 32'(bit_din), 32'(it.din));
          repeat (2) @(negedge clk);
          bit_dout = it.dout;
          if (it.arb) arb = 1'b1;
          else        bit_done = 1'b1;
          @(negedge clk);
          bit_done = 1'b0;
          arb      = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk("R12", "prescale", 32'(prescale), 32'hFFFF);
    chk("R12", "irq", 32'(irq), 0);
    chk("R12", "bit_cmd", 32'(bit_cmd), 0);
    rd_reg(2, v); chk("R12", "control", v, 0);
    rd_reg(3, v); chk("R12", "data", v, 0);
    rd_reg(4, v); chk("R12", "status", v, 0);

    // R1 prescale map, R2 upper bits
    wr_reg(0, 32'h34);
    wr_reg(1, 32'h12);
    chk("R1", "prescale_o", 32'(prescale), 32'h1234);
    rd_reg(1, v); chk("R1", "prescale hi", v, 32'h12);
    wr_reg(0, 32'hABCD_EF56);
    rd_reg(0, v); chk("R2", "prescale lo wide write", v, 32'h56);
    wr_reg(0, 32'h34);

    // R11 disabled core ignores commands
    wr_reg(3, 32'hA5);
    wr_reg(4, 32'h91);
    rd_reg(4, v); chk("R11", "status while off", v, 0);
    repeat (20) @(negedge clk);
    chk("R11", "bit_cmd while off", 32'(bit_cmd), 0);

    // R3 enable
    wr_reg(2, 32'h80);
    chk("R3", "core_en_o", 32'(core_en), 1);
    rd_reg(2, v); chk("R3", "control readback", v, 32'h80);

    // R4 start + write byte, ACK
    wr_reg(3, 32'hA4);
    push(C_START, 1'b1, 1'b0, 1'b0);
    push_wbyte(8'hA4, 1'b0);
    wr_reg(4, 32'h90);
    rd_reg(4, v); chk("R4", "tip after command", 32'(v[1]), 1);
    wait_idle();
    rd_reg(4, v); chk("R4", "status after write", v, 32'h01);
    chk("R4", "queue drained", exp_q.size(), 0);
    chk("R8", "irq with ien off", 32'(irq), 0);

    // R8 / R7
    wr_reg(2, 32'hC0);
    chk("R8", "irq with ien on", 32'(irq), 1);
    wr_reg(4, 32'h01);
    rd_reg(4, v); chk("R7", "iack clears flag", v, 0);
    chk("R7", "irq after iack", 32'(irq), 0);

    // R6 write with NACK
    wr_reg(3, 32'h3C);
    push_wbyte(8'h3C, 1'b1);
    wr_reg(4, 32'h10);
    wait_idle();
    rd_reg(4, v); chk("R6", "nack status", v, 32'h81);

    // R5 read with NACK and stop
    push_rbyte(8'hC3, 1'b1);
    push(C_STOP, 1'b1, 1'b0, 1'b0);
    wr_reg(4, 32'h69);
    wait_idle();
    rd_reg(4, v); chk("R5", "status after read", v, 32'h81);
    rd_reg(3, v); chk("R5", "rx byte", v, 32'hC3);
    chk("R5", "queue drained", exp_q.size(), 0);

    // R5 read with ACK
    push_rbyte(8'h5A, 1'b0);
    wr_reg(4, 32'h21);
    wait_idle();
    rd_reg(3, v); chk("R5", "rx byte ack", v, 32'h5A);

    // R10 bus busy
    busy = 1'b1;
    rd_reg(4, v); chk("R10", "busy set", 32'(v[6]), 1);
    busy = 1'b0;
    rd_reg(4, v); chk("R10", "busy clear", 32'(v[6]), 0);

    // R9 arbitration lost
    wr_reg(4, 32'h01);
    wr_reg(3, 32'h50);
    push(C_START, 1'b1, 1'b0, 1'b1);
    wr_reg(4, 32'h91);
    wait_idle();
    rd_reg(4, v); chk("R9", "status after arb", v, 32'hA1);
    chk("R9", "bit_cmd idle", 32'(bit_cmd), 0);
    chk("R9", "queue drained", exp_q.size(), 0);
    wr_reg(4, 32'h01);
    rd_reg(4, v); chk("R9", "al held over iack", v, 32'hA0);
    push(C_START, 1'b1, 1'b0, 1'b0);
    wr_reg(4, 32'h80);
    wait_idle();
    rd_reg(4, v); chk("R9", "al cleared by start", v, 32'h81);

    // R11 disable keeps flag, ignores iack, prescale writable
    wr_reg(2, 32'h40);
    chk("R11", "core_en off", 32'(core_en), 0);
    chk("R8", "irq gated by enable", 32'(irq), 0);
    wr_reg(4, 32'h01);
    wr_reg(0, 32'h77);
    chk("R11", "prescale while off", 32'(prescale), 32'h1277);
    wr_reg(2, 32'hC0);
    chk("R11", "flag kept", 32'(irq), 1);
    rd_reg(4, v); chk("R11", "status flag kept", 32'(v[0]), 1);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule